// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block maps a 32-bit linear address onto a 32-bit physical address by walking a two-level page table held in memory. Software first loads the page directory base through a write strobe. Each translation request then carries an enable bit.

When the enable bit is clear, the linear address comes back unchanged after one cycle and memory is not touched. When it is set, the walker makes two reads in sequence over a single 32-bit read port. The first read fetches the directory entry. That entry points to a second-level table, and the second read fetches the page entry from it. The frame number in the page entry is then joined with the in-page byte offset.

Every entry carries a present flag in bit 0. When the flag is clear in either entry, the walk stops and reports a fault instead of an address. Only one translation is in flight at a time. Each result is announced by a one-cycle response pulse.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid` and `mem_req` are 0.
- R2: A request accepted with `pg_enable` = 0 gives `rsp_valid` = 1 in the next cycle, with `rsp_paddr` equal to the request address and `rsp_fault` = 0. No memory read is issued.
- R3: With paging on, the first read is at the directory base plus four times the directory index. The directory index is bits [31:22] of the linear address.
- R4: When the directory entry has bit 0 set, the second read is at entry bits [31:12] shifted left by 12, plus four times the table index. The table index is bits [21:12] of the linear address.
- R5: When the page entry has bit 0 set, the response carries entry bits [31:12] as `rsp_paddr[31:12]`, linear bits [11:0] as `rsp_paddr[11:0]`, and `rsp_fault` = 0.
- R6: A directory entry with bit 0 clear ends the walk with `rsp_fault` = 1 and `rsp_paddr` = 0. No second read is made.
- R7: A page entry with bit 0 clear gives `rsp_fault` = 1 and `rsp_paddr` = 0.
- R8: Writing the base register with `base_we` = 1 stores only bits [31:12] of `base_wdata`. The low 12 bits of the stored base are zero.
- R9: From acceptance until the response cycle, `req_ready` is 0, and any `req_valid` in that interval is ignored. `rsp_valid` lasts exactly one cycle per accepted request.
- R10: While `mem_req` is 1 and `mem_ack` is 0, `mem_addr` holds its value. A base write made during a walk does not change the directory address of that walk.
- R11: Entry bits [11:1] have no effect on either the next read address or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_we | input | 1 | Load strobe for the directory base |
| base_wdata | input | 32 | New directory base (low 12 bits dropped) |
| pg_enable | input | 1 | Paging on for the request being accepted |
| req_valid | input | 1 | Translation request present |
| req_laddr | input | 32 | Linear address to translate |
| req_ready | output | 1 | Walker idle, request will be taken |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Not-present entry met during the walk |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_ack | input | 1 | Read done; `mem_rdata` valid this cycle |
| mem_rdata | input | 32 | Entry returned by memory |

## Verification
The walker is driven with bypass requests and with fully mapped addresses at both ends of the index range, including all-zero and all-ones addresses. This shows that the index fields and the offset are placed correctly. Missing directory entries and missing page entries are tried separately, which shows whether a walk stops early or goes on to a second read. Entries with junk in their low bits, a base written with junk in its low bits, and a base rewritten in the middle of a walk show which bits are really ignored. Memory latency is varied from zero to several cycles, and spurious requests are raised during a walk. Together these show that addresses are held stable and that only one translation is ever in flight.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int AW     = 32;
  localparam int DIR_W  = 10;
  localparam int TBL_W  = 10;
  localparam int OFS_W  = AW - DIR_W - TBL_W;
  localparam int FRM_W  = AW - OFS_W;
  localparam int ENT_SH = 2;

  typedef logic [AW-1:0]    addr_t;
  typedef logic [FRM_W-1:0] frame_t;
  typedef logic [OFS_W-1:0] ofs_t;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_READ_DIR = 2'd1,
    ST_READ_TBL = 2'd2,
    ST_DONE     = 2'd3
  } walk_state_e;

  function automatic addr_t dir_index(addr_t la);
    return addr_t'(la[AW-1 -: DIR_W]);
  endfunction

  function automatic addr_t tbl_index(addr_t la);
    return addr_t'(la[OFS_W +: TBL_W]);
  endfunction

  function automatic ofs_t page_offset(addr_t la);
    return la[OFS_W-1:0];
  endfunction

  function automatic frame_t entry_frame(addr_t ent);
    return ent[AW-1:OFS_W];
  endfunction

  function automatic logic entry_present(addr_t ent);
    return ent[0];
  endfunction

  function automatic addr_t slot_address(frame_t tbl_base, addr_t idx);
    return {tbl_base, {OFS_W{1'b0}}} + (idx << ENT_SH);
  endfunction

  function automatic addr_t join_page(frame_t frm, ofs_t ofs);
    return {frm, ofs};
  endfunction
endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg
  import ptw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  addr_t  wr_data,
  output frame_t base_frame
);
  logic unused_low_bits;
  assign unused_low_bits = ^wr_data[OFS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      base_frame <= '0;
    else if (wr_en)
      base_frame <= entry_frame(wr_data);
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  addr_t  laddr_q,
  input  frame_t walk_base,
  input  frame_t tbl_frame,
  input  frame_t ent_frame,
  output addr_t  dir_addr,
  output addr_t  tbl_addr,
  output addr_t  phys_addr
);
  always_comb begin
    dir_addr  = slot_address(walk_base, dir_index(laddr_q));
    tbl_addr  = slot_address(tbl_frame, tbl_index(laddr_q));
    phys_addr = join_page(ent_frame, page_offset(laddr_q));
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  addr_t  req_laddr,
  input  logic   pg_enable,
  input  frame_t base_frame,
  input  logic   mem_ack,
  input  addr_t  mem_rdata,
  input  addr_t  dir_addr,
  input  addr_t  tbl_addr,
  input  addr_t  phys_addr,
  output logic   req_ready,
  output logic   rsp_valid,
  output addr_t  rsp_paddr,
  output logic   rsp_fault,
  output logic   mem_req,
  output addr_t  mem_addr,
  output addr_t  laddr_q,
  output frame_t walk_base,
  output frame_t tbl_frame,
  output frame_t ent_frame
);
  walk_state_e state_q;
  addr_t       result_q;
  logic        fault_q;

  logic acc_fire, ent_ok, dir_hit, dir_miss, tbl_hit, tbl_miss;
  logic unused_flag_bits;

  assign unused_flag_bits = ^mem_rdata[OFS_W-1:1];

  assign ent_frame = entry_frame(mem_rdata);
  assign ent_ok    = entry_present(mem_rdata);
  assign acc_fire  = (state_q == ST_IDLE) && req_valid;
  assign dir_hit   = (state_q == ST_READ_DIR) && mem_ack && ent_ok;
  assign dir_miss  = (state_q == ST_READ_DIR) && mem_ack && !ent_ok;
  assign tbl_hit   = (state_q == ST_READ_TBL) && mem_ack && ent_ok;
  assign tbl_miss  = (state_q == ST_READ_TBL) && mem_ack && !ent_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      laddr_q   <= '0;
      walk_base <= '0;
      tbl_frame <= '0;
      result_q  <= '0;
      fault_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (acc_fire) begin
          laddr_q   <= req_laddr;
          walk_base <= base_frame;
          if (pg_enable) begin
            state_q <= ST_READ_DIR;
          end else begin
            result_q <= req_laddr;
            fault_q  <= 1'b0;
            state_q  <= ST_DONE;
          end
        end
        ST_READ_DIR: begin
          if (dir_hit) begin
            tbl_frame <= ent_frame;
            state_q   <= ST_READ_TBL;
          end else if (dir_miss) begin
            result_q <= '0;
            fault_q  <= 1'b1;
            state_q  <= ST_DONE;
          end
        end
        ST_READ_TBL: begin
          if (tbl_hit) begin
            result_q <= phys_addr;
            fault_q  <= 1'b0;
            state_q  <= ST_DONE;
          end else if (tbl_miss) begin
            result_q <= '0;
            fault_q  <= 1'b1;
            state_q  <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (state_q == ST_IDLE);
    rsp_valid = (state_q == ST_DONE);
    rsp_paddr = result_q;
    rsp_fault = fault_q;
    mem_req   = (state_q == ST_READ_DIR) || (state_q == ST_READ_TBL);
    mem_addr  = (state_q == ST_READ_TBL) ? tbl_addr : dir_addr;
  end

  // R9
  one_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> !req_ready);

  // R9
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !pg_enable) |=> (rsp_valid && !mem_req && !rsp_fault));

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R6
  dir_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_miss |=> (rsp_valid && rsp_fault && !mem_req && rsp_paddr == '0));

  // R5
  tbl_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_hit |=> (rsp_valid && !rsp_fault &&
                 rsp_paddr[AW-1:OFS_W] == $past(mem_rdata[AW-1:OFS_W]) &&
                 rsp_paddr[OFS_W-1:0] == laddr_q[OFS_W-1:0]));

  // R7
  tbl_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_miss |=> (rsp_valid && rsp_fault && rsp_paddr == '0));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic [31:0]   base_wdata,
  input  logic          pg_enable,
  input  logic          req_valid,
  input  logic [31:0]   req_laddr,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [31:0]   rsp_paddr,
  output logic          rsp_fault,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata
);
  frame_t base_frame, walk_base, tbl_frame, ent_frame;
  addr_t  laddr_q, dir_addr, tbl_addr, phys_addr;

  ptw_base_reg u_base (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (base_we),
    .wr_data    (base_wdata),
    .base_frame (base_frame)
  );

  ptw_addr_gen u_agen (
    .laddr_q   (laddr_q),
    .walk_base (walk_base),
    .tbl_frame (tbl_frame),
    .ent_frame (ent_frame),
    .dir_addr  (dir_addr),
    .tbl_addr  (tbl_addr),
    .phys_addr (phys_addr)
  );

  ptw_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_laddr  (req_laddr),
    .pg_enable  (pg_enable),
    .base_frame (base_frame),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .dir_addr   (dir_addr),
    .tbl_addr   (tbl_addr),
    .phys_addr  (phys_addr),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_paddr  (rsp_paddr),
    .rsp_fault  (rsp_fault),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .laddr_q    (laddr_q),
    .walk_base  (walk_base),
    .tbl_frame  (tbl_frame),
    .ent_frame  (ent_frame)
  );
endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        pg_enable = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_laddr = '0;
  logic        req_ready, rsp_valid, rsp_fault, mem_req;
  logic [31:0] rsp_paddr, mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .pg_enable(pg_enable), .req_valid(req_valid), .req_laddr(req_laddr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  int mem_lat = 0;
  int wait_cnt = 0;
  logic [31:0] cur_base = '0;

  logic [31:0] mem_img [logic [31:0]];
  logic [31:0] exp_paddr [$];
  logic        exp_fault [$];
  string       exp_tag   [$];
  logic [31:0] exp_maddr [$];
  string       exp_mtag  [$];

  function automatic logic [31:0] rd(logic [31:0] a);
    if (mem_img.exists(a)) return mem_img[a];
    return 32'h0;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // driver: predicts the walk, then presents the request
  task automatic issue(logic [31:0] la, logic en, string tag);
    logic [31:0] da, de, ta, pe;
    if (!en) begin
      exp_paddr.push_back(la); exp_fault.push_back(1'b0); exp_tag.push_back(tag);
    end else begin
      da = {cur_base[31:12], la[31:22], 2'b00};
      exp_maddr.push_back(da); exp_mtag.push_back({tag, "/R3"});
      de = rd(da);
      if (!de[0]) begin
        exp_paddr.push_back(32'h0); exp_fault.push_back(1'b1); exp_tag.push_back(tag);
      end else begin
        ta = {de[31:12], la[21:12], 2'b00};
        exp_maddr.push_back(ta); exp_mtag.push_back({tag, "/R4"});
        pe = rd(ta);
        if (!pe[0]) begin
          exp_paddr.push_back(32'h0); exp_fault.push_back(1'b1); exp_tag.push_back(tag);
        end else begin
          exp_paddr.push_back({pe[31:12], la[11:0]}); exp_fault.push_back(1'b0);
          exp_tag.push_back(tag);
        end
      end
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_laddr = la; pg_enable = en;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (exp_paddr.size() != 0 || exp_maddr.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_base(logic [31:0] v);
    @(negedge clk);
    base_we = 1'b1; base_wdata = v;
    @(negedge clk);
    base_we = 1'b0;
    cur_base = {v[31:12], 12'h000};
  endtask

  // monitor: responses and memory model
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (exp_paddr.size() == 0) begin
          chk(0, "R9", "unexpected response", rsp_paddr, 32'h0);
        end else begin
          logic [31:0] ep; logic ef; string t;
          ep = exp_paddr.pop_front(); ef = exp_fault.pop_front(); t = exp_tag.pop_front();
          chk(rsp_paddr == ep, t, "paddr", rsp_paddr, ep);
          chk(rsp_fault == ef, t, "fault", {31'h0, rsp_fault}, {31'h0, ef});
        end
      end
      if (mem_req) begin
        if (wait_cnt >= mem_lat) begin
          if (exp_maddr.size() == 0) begin
            chk(0, "R2/R6", "unexpected read", mem_addr, 32'h0);
          end else begin
            logic [31:0] ea; string t;
            ea = exp_maddr.pop_front(); t = exp_mtag.pop_front();
            chk(mem_addr == ea, t, "read address", mem_addr, ea);
          end
          mem_ack = 1'b1; mem_rdata = rd(mem_addr); wait_cnt = 0;
        end else begin
          mem_ack = 1'b0; wait_cnt++;
        end
      end else begin
        mem_ack = 1'b0; wait_cnt = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // memory image
    mem_img[32'h0010_0004] = 32'h0020_0001;
    mem_img[32'h0020_000C] = 32'h1234_5001;
    mem_img[32'h0010_0FFC] = 32'h0030_0FFF;           // junk low bits R11
    mem_img[32'h0030_0FFC] = 32'hABCD_E00F;           // junk low bits R11
    mem_img[32'h0010_0008] = 32'h0050_0000;           // not present R6
    mem_img[32'h0020_0014] = 32'h7777_7000;           // not present R7
    mem_img[32'h0060_0004] = 32'h0020_0001;
    for (int t = 0; t < 8; t++)
      if (t != 3 && t != 5)
        mem_img[32'h0020_0000 + t*4] = {20'h40000 + 20'(t*'h111), 12'h001};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(req_ready == 1'b1, "R1", "req_ready after reset", {31'h0, req_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", {31'h0, mem_req}, 32'h0);

    set_base(32'h0010_0000);

    issue(32'hDEAD_BEEF, 1'b0, "R2"); wait_done();
    issue(32'h0040_3ABC, 1'b1, "R5"); wait_done();
    issue(32'hFFFF_FFFF, 1'b1, "R11"); wait_done();
    issue(32'h0080_0123, 1'b1, "R6"); wait_done();
    issue(32'h0040_5010, 1'b1, "R7"); wait_done();
    issue(32'h0000_0000, 1'b1, "R6"); wait_done();

    for (int t = 0; t < 8; t++) begin
      mem_lat = t % 4;
      issue(32'h0040_0000 | (t << 12) | (t * 32'h151), 1'b1, "R4");
    end
    wait_done();

    // R8: junk low bits in the base are dropped
    mem_lat = 1;
    set_base(32'h0060_0ABC);
    issue(32'h0040_3123, 1'b1, "R8"); wait_done();

    // R10: base rewrite during a walk, slow memory
    mem_lat = 5;
    issue(32'h0040_3777, 1'b1, "R10");
    set_base(32'h0010_0000);
    wait_done();

    // R9: spurious requests during a walk are ignored
    mem_lat = 6;
    issue(32'h0040_3001, 1'b1, "R9");
    req_valid = 1'b1; req_laddr = 32'hDEAD_BEEF; pg_enable = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R9", "req_ready during walk", {31'h0, req_ready}, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();

    // bypass back to back with walks, zero latency
    mem_lat = 0;
    issue(32'h1357_9BDF, 1'b0, "R2");
    issue(32'hFFFF_F000, 1'b1, "R11");
    wait_done();

    summary();
  end
endmodule